// File: doc/BRIEF.md
# Packed Multiply Pairwise-Add Unit

This block is a SIMD datapath stage. It takes two 64-bit operands and splits each into four signed 16-bit elements. In its dot mode it multiplies the elements at matching positions, giving four 32-bit products. It then adds neighbouring products two at a time and packs the two 32-bit sums into one 64-bit result. This is the inner step of short fixed-point dot products and filters.

A second mode adds the operands lane by lane as four independent 16-bit sums. No carry crosses a lane boundary. Both modes go through one output register, so a result appears one cycle after its operands are presented with the valid strobe. The result register keeps its value while no new operands arrive.

Top module: `pmadd_unit`

## Requirements
- R1: While `rst_n` is low, at every rising clock edge `out_valid` becomes 0 and `result` becomes all zeros.
- R2: After reset, `out_valid` at a rising edge equals `in_valid` as it was sampled at the previous rising edge (one-cycle latency).
- R3: With `mode` = 0 (dot mode), the result registered for an accepted operand pair has bits 31:0 equal to a0*b0 + a1*b1 and bits 63:32 equal to a2*b2 + a3*b3. All elements are signed two's complement and each product is a full 32-bit value.
- R4: Element k of each operand occupies bits 16k+15 down to 16k. Sum 0 is formed from elements 0 and 1 and sits in bits 31:0. Sum 1 is formed from elements 2 and 3 and sits in bits 63:32.
- R5: Each dot-mode sum wraps modulo 2^32. With every element at -32768, each sum is 0x80000000.
- R6: With `mode` = 1 (add mode), lane k of the result is (a_k + b_k) modulo 2^16. A carry out of one lane never reaches the next lane.
- R7: At a rising edge where `in_valid` is low, `result` keeps its previous value whatever `src_a`, `src_b` and `mode` carry.
- R8: `mode` is sampled together with the operands at the edge where `in_valid` is high. The same operands give the dot-mode or the add-mode result according to that sampled value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 1 | 0: multiply then pairwise add; 1: lane-wise add |
| src_a | input | 64 | First operand, four signed 16-bit elements |
| src_b | input | 64 | Second operand, four signed 16-bit elements |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Two 32-bit pair sums, or four 16-bit lane sums |

## Verification
The bound checker compares every accepted operand pair against its own model of both modes. It also checks on every cycle that `out_valid` trails `in_valid` by one edge, that `result` is frozen on idle cycles, and that reset clears the outputs.

Some behaviours can only be shown by the bench's directed cases, with chosen values whose expected results are known beforehand:
- element placement, using a single nonzero lane;
- the exact wrap point of a pair sum;
- a lane overflow that must not disturb its neighbour;
- one operand pair presented in both modes.

// File: rtl/pmadd_pkg.sv
// Package: shared constants and the mode encoding for the packed
// multiply pairwise-add unit. Assumes an even number of lanes.
package pmadd_pkg;

    // Default element width and lane count of the datapath.
    localparam int DEF_ELEM_W = 16;
    localparam int DEF_LANES  = 4;

    // Operation selected by the mode input.
    typedef enum logic {
        MODE_DOT = 1'b0,   // multiply lanes, add adjacent products
        MODE_ADD = 1'b1    // independent lane-wise add
    } pmadd_mode_e;

endpackage

// File: rtl/pmadd_mul_array.sv
// Module: pmadd_mul_array
// Multiplies the signed elements at matching positions of two packed
// operands. Each product has twice the element width. Purely
// combinational. Assumes two's complement elements.
module pmadd_mul_array #(
    parameter int ELEM_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANES*ELEM_W-1:0]   op_a,
    input  logic [LANES*ELEM_W-1:0]   op_b,
    output logic [LANES*2*ELEM_W-1:0] prod_flat
);
    localparam int PROD_W = 2 * ELEM_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ELEM_W-1:0] ea;
        logic [ELEM_W-1:0] eb;
        logic [PROD_W-1:0] xa;
        logic [PROD_W-1:0] xb;
        logic [PROD_W-1:0] prod;

        // Pick out the elements of this lane.
        assign ea = op_a[k*ELEM_W +: ELEM_W];
        assign eb = op_b[k*ELEM_W +: ELEM_W];

        // Sign-extend both elements to the full product width.
        assign xa = {{ELEM_W{ea[ELEM_W-1]}}, ea};
        assign xb = {{ELEM_W{eb[ELEM_W-1]}}, eb};

        // The low PROD_W bits of the extended product are the signed product.
        always_comb begin
            prod = xa * xb;
        end

        assign prod_flat[k*PROD_W +: PROD_W] = prod;
    end

endmodule

// File: rtl/pmadd_pair_reduce.sv
// Module: pmadd_pair_reduce
// Adds each even-indexed product to its odd neighbour. This halves the
// number of lanes while keeping the product width. Sums wrap modulo
// 2^PROD_W. Assumes LANES is even.
module pmadd_pair_reduce #(
    parameter int PROD_W = 32,
    parameter int LANES  = 4
) (
    input  logic [LANES*PROD_W-1:0]     prod_flat,
    output logic [(LANES/2)*PROD_W-1:0] sum_flat
);
    localparam int PAIRS = LANES / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic [PROD_W-1:0] lo_prod;
        logic [PROD_W-1:0] hi_prod;

        // Products 2p and 2p+1 form pair p.
        assign lo_prod = prod_flat[(2*p)*PROD_W +: PROD_W];
        assign hi_prod = prod_flat[(2*p+1)*PROD_W +: PROD_W];

        // Wrapping sum of the pair.
        assign sum_flat[p*PROD_W +: PROD_W] = lo_prod + hi_prod;
    end

endmodule

// File: rtl/pmadd_lane_add.sv
// Module: pmadd_lane_add
// Lane-wise packed add. Each lane sum is truncated to the element width,
// so no carry crosses a lane boundary. Purely combinational.
module pmadd_lane_add #(
    parameter int ELEM_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANES*ELEM_W-1:0] op_a,
    input  logic [LANES*ELEM_W-1:0] op_b,
    output logic [LANES*ELEM_W-1:0] sum_flat
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Per-lane adder; its carry out is dropped.
        assign sum_flat[k*ELEM_W +: ELEM_W] =
            op_a[k*ELEM_W +: ELEM_W] + op_b[k*ELEM_W +: ELEM_W];
    end

endmodule

// File: rtl/pmadd_out_stage.sv
// Module: pmadd_out_stage
// Output register with a synchronous active-low reset.
// - The valid flag follows the input strobe on every cycle.
// - The data register loads only on strobed cycles and holds otherwise.
module pmadd_out_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              vld_q,
    output logic [DATA_W-1:0] dout_q
);
    // Valid pipeline bit: cleared by reset, otherwise copies the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= load;
    end

    // Data register: cleared by reset, loaded on strobe, held when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout_q <= '0;
        else if (load) dout_q <= din;
    end

endmodule

// File: rtl/pmadd_unit.sv
// Module: pmadd_unit (top)
// Packed multiply pairwise-add unit with a lane-wise add mode.
// - Dot mode: multiplies signed elements and adds adjacent products into
//   double-width sums.
// - Add mode: adds lanes independently at the element width.
// The result is registered, giving one cycle of latency.
// Assumes LANES is even, so LANES*ELEM_W equals (LANES/2)*2*ELEM_W.
module pmadd_unit #(
    parameter int ELEM_W = pmadd_pkg::DEF_ELEM_W,
    parameter int LANES  = pmadd_pkg::DEF_LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    mode,
    input  logic [LANES*ELEM_W-1:0] src_a,
    input  logic [LANES*ELEM_W-1:0] src_b,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] result
);
    import pmadd_pkg::*;

    localparam int DATA_W = LANES * ELEM_W;
    localparam int PROD_W = 2 * ELEM_W;
    localparam int PAIRS  = LANES / 2;

    logic [LANES*PROD_W-1:0] prod_flat;
    logic [PAIRS*PROD_W-1:0] dot_flat;
    logic [DATA_W-1:0]       add_flat;
    logic [DATA_W-1:0]       next_result;
    pmadd_mode_e             op_sel;

    // Lane multipliers.
    pmadd_mul_array #(.ELEM_W(ELEM_W), .LANES(LANES)) u_mul (
        .op_a      (src_a),
        .op_b      (src_b),
        .prod_flat (prod_flat)
    );

    // Adjacent-product reduction.
    pmadd_pair_reduce #(.PROD_W(PROD_W), .LANES(LANES)) u_red (
        .prod_flat (prod_flat),
        .sum_flat  (dot_flat)
    );

    // Lane-wise adder for the add mode.
    pmadd_lane_add #(.ELEM_W(ELEM_W), .LANES(LANES)) u_add (
        .op_a     (src_a),
        .op_b     (src_b),
        .sum_flat (add_flat)
    );

    // Decode the mode pin into the package encoding.
    assign op_sel = pmadd_mode_e'(mode);

    // Choose the datapath result for the selected operation.
    always_comb begin
        unique case (op_sel)
            MODE_DOT: next_result = dot_flat;
            MODE_ADD: next_result = add_flat;
            default:  next_result = dot_flat;
        endcase
    end

    // Registered output stage.
    pmadd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_valid),
        .din    (next_result),
        .vld_q  (out_valid),
        .dout_q (result)
    );

endmodule

// File: rtl/pmadd_unit_checker.sv
// Module: pmadd_unit_checker
// Property checker for pmadd_unit, bound to every instance of it.
// - Holds its own model of both modes, built from the ports.
// - Checks valid timing, hold on idle cycles and reset clearing.
module pmadd_unit_checker #(
    parameter int ELEM_W = 16,
    parameter int LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    mode,
    input logic [LANES*ELEM_W-1:0] src_a,
    input logic [LANES*ELEM_W-1:0] src_b,
    input logic                    out_valid,
    input logic [LANES*ELEM_W-1:0] result
);
    localparam int DATA_W = LANES * ELEM_W;
    localparam int PROD_W = 2 * ELEM_W;

    logic [DATA_W-1:0] model_dot;
    logic [DATA_W-1:0] model_add;

    // Reference model: signed products summed per pair, and lane sums.
    always_comb begin
        model_dot = '0;
        model_add = '0;
        for (int p = 0; p < LANES / 2; p++) begin
            logic signed [PROD_W-1:0] s;
            s = PROD_W'($signed(src_a[(2*p)*ELEM_W +: ELEM_W]) *
                        $signed(src_b[(2*p)*ELEM_W +: ELEM_W]))
              + PROD_W'($signed(src_a[(2*p+1)*ELEM_W +: ELEM_W]) *
                        $signed(src_b[(2*p+1)*ELEM_W +: ELEM_W]));
            model_dot[p*PROD_W +: PROD_W] = s;
        end
        for (int k = 0; k < LANES; k++) begin
            model_add[k*ELEM_W +: ELEM_W] =
                src_a[k*ELEM_W +: ELEM_W] + src_b[k*ELEM_W +: ELEM_W];
        end
    end

    // R1: reset clears the outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R2: a strobe produces valid on the next edge.
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe gives no valid on the next edge.
    p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: dot-mode result matches the model.
    p_dot_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode) |=> (result == $past(model_dot)));

    // R6: add-mode result matches the model.
    p_add_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode) |=> (result == $past(model_add)));

    // R7: idle cycles leave the result untouched.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

endmodule

bind pmadd_unit pmadd_unit_checker #(.ELEM_W(ELEM_W), .LANES(LANES)) u_pmadd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pmadd_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for pmadd_unit. Each task drives one scenario and
// checks its own results.
module pmadd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    pmadd_unit u_pmadd_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Compare one observed value with its expected value.
    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Pack four 16-bit elements, element 0 in the low bits.
    function automatic logic [63:0] pack4(input logic [15:0] e0, input logic [15:0] e1,
                                          input logic [15:0] e2, input logic [15:0] e3);
        return {e3, e2, e1, e0};
    endfunction

    // Expected dot-mode result, computed from the requirement.
    function automatic logic [63:0] exp_dot(input logic [63:0] a, input logic [63:0] b);
        int s0;
        int s1;
        s0 = int'(shortint'(a[15:0]))  * int'(shortint'(b[15:0]))
           + int'(shortint'(a[31:16])) * int'(shortint'(b[31:16]));
        s1 = int'(shortint'(a[47:32])) * int'(shortint'(b[47:32]))
           + int'(shortint'(a[63:48])) * int'(shortint'(b[63:48]));
        return {s1, s0};
    endfunction

    // Expected add-mode result, computed per lane.
    function automatic logic [63:0] exp_add(input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        for (int k = 0; k < 4; k++) r[k*16 +: 16] = a[k*16 +: 16] + b[k*16 +: 16];
        return r;
    endfunction

    // Present one operand pair for a cycle; leave the sampling point on a falling edge.
    task automatic issue(input logic m, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        mode = m;
        src_a = a;
        src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // R1: outputs are cleared while reset is held.
    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b1;
        src_a = 64'hFFFF_FFFF_FFFF_FFFF;
        src_b = 64'h1;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R1 result in reset", result, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R3: small positive dot product.
    task automatic t_dot_basic;
        logic [63:0] a;
        logic [63:0] b;
        a = pack4(16'd1, 16'd2, 16'd3, 16'd4);
        b = pack4(16'd5, 16'd6, 16'd7, 16'd8);
        issue(1'b0, a, b);
        check("R3 dot basic", result, {32'd53, 32'd17});
        check("R3 dot basic model", result, exp_dot(a, b));
    endtask

    // R3: signed elements, including mixed signs.
    task automatic t_dot_signed;
        logic [63:0] a;
        logic [63:0] b;
        a = pack4(16'hFFFD, 16'd100, 16'h8001, 16'h7FFF);
        b = pack4(16'd7, 16'hFFF6, 16'd2, 16'hFFFF);
        issue(1'b0, a, b);
        check("R3 dot signed", result, exp_dot(a, b));
        a = pack4(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        issue(1'b0, a, a);
        check("R3 dot minus one squared", result, {32'd2, 32'd2});
    endtask

    // R4: element placement, one nonzero lane at a time.
    task automatic t_dot_position;
        issue(1'b0, pack4(16'd0, 16'd0, 16'd0, 16'd2), pack4(16'd0, 16'd0, 16'd0, 16'd3));
        check("R4 element 3 lands in high sum", result, {32'd6, 32'd0});
        issue(1'b0, pack4(16'd0, 16'd9, 16'd0, 16'd0), pack4(16'd0, 16'd4, 16'd0, 16'd0));
        check("R4 element 1 lands in low sum", result, {32'd0, 32'd36});
    endtask

    // R5: pair sums wrap modulo 2^32.
    task automatic t_dot_wrap;
        logic [63:0] a;
        a = pack4(16'h8000, 16'h8000, 16'h8000, 16'h8000);
        issue(1'b0, a, a);
        check("R5 wrap at most negative", result, {32'h8000_0000, 32'h8000_0000});
    endtask

    // R6: lane-wise add with no carry across lanes.
    task automatic t_add_lanes;
        logic [63:0] a;
        logic [63:0] b;
        a = pack4(16'hFFFF, 16'h0000, 16'h8000, 16'h1234);
        b = pack4(16'h0001, 16'h0000, 16'h8000, 16'h1111);
        issue(1'b1, a, b);
        check("R6 add no inter-lane carry", result, pack4(16'h0000, 16'h0000, 16'h0000, 16'h2345));
        a = 64'h0123_4567_89AB_CDEF;
        b = 64'hFEDC_BA98_7654_3210;
        issue(1'b1, a, b);
        check("R6 add pattern", result, exp_add(a, b));
    endtask

    // R8: same operands under both modes.
    task automatic t_mode_select;
        logic [63:0] a;
        logic [63:0] b;
        a = pack4(16'd10, 16'd20, 16'd30, 16'd40);
        b = pack4(16'd1, 16'd2, 16'd3, 16'd4);
        issue(1'b0, a, b);
        check("R8 mode 0 gives dot", result, {32'd250, 32'd50});
        issue(1'b1, a, b);
        check("R8 mode 1 gives add", result, pack4(16'd11, 16'd22, 16'd33, 16'd44));
    endtask

    // R2: valid follows the strobe by one cycle.
    task automatic t_valid_timing;
        @(negedge clk);
        in_valid = 1'b1;
        check("R2 no valid before edge", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid one cycle after strobe", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R2 valid drops after strobe ends", {63'd0, out_valid}, 64'd0);
    endtask

    // R7: idle cycles leave the result unchanged.
    task automatic t_hold;
        logic [63:0] held;
        issue(1'b0, pack4(16'd3, 16'd3, 16'd3, 16'd3), pack4(16'd2, 16'd2, 16'd2, 16'd2));
        held = result;
        @(negedge clk);
        mode = 1'b1;
        src_a = 64'hAAAA_5555_AAAA_5555;
        src_b = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(negedge clk);
        check("R7 result held while idle", result, held);
        check("R7 held value", held, {32'd12, 32'd12});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_dot_basic();
        t_dot_signed();
        t_dot_position();
        t_dot_wrap();
        t_add_lanes();
        t_mode_select();
        t_valid_timing();
        t_hold();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule